// File: doc/BRIEF.md
# SPI Master Chip-Select Steering and Mode-Fault Guard

This unit sits between the transfer engine of an SPI master and its four active-low slave-select pins. For every transfer it works out which slave the 4-bit select code addresses, drives the matching pin pattern while the engine reports a transfer in progress, and tells the engine which of four per-slave configuration sets (clock rate, word length, phase and polarity) to apply. The select code comes either from a mode setting held by software (fixed select) or from the select field carried with each transmit word (variable select).

Two pin encodings are offered. In direct mode each pin belongs to one slave, and a code with more than one zero bit is resolved to the lowest-numbered zero. In decoder mode the code is placed on the pins as-is for an external decoder, so fifteen slaves can be reached, the all-ones code meaning no slave, and configuration sets are shared by groups of four codes.

The unit also guards select pin 0 as an input. If another device pulls it low while this controller is an enabled master, the unit raises a sticky fault flag and withdraws the controller enable, which software must restore by writing the enable bit again.

Top module: `spi_sel_guard`

## Requirements
- R1: After reset all four select outputs `cs_n` are high, `fault` is 0 and `ctl_en` is 0.
- R2: With `fixed_sel`=1 the select code is `mr_code`; changes on `tx_code` have no effect on `cs_n`, `cfg_idx` or `sel_ok`.
- R3: With `fixed_sel`=0 the select code is `tx_code`; `mr_code` has no effect.
- R4: In direct mode (`dec_en`=0) a valid code selects the lowest-numbered bit position k that is 0; one clock edge after the request, `cs_n` has only bit k low, and `cfg_idx` equals k combinationally.
- R5: The code 4'hF is invalid in both modes: `sel_ok` is 0 and `cs_n` stays 4'hF even while a transfer is requested; any other code gives `sel_ok`=1.
- R6: In decoder mode (`dec_en`=1) a valid code appears unchanged on `cs_n` one edge after the request, and `cfg_idx` is 0 for codes 0-3, 1 for 4-7, 2 for 8-11 and 3 for 12-14.
- R7: `cs_n` is 4'hF one edge after any cycle in which `xfer_active` is 0 or `ctl_en` is 0.
- R8: When `ss0_in` is held low while `ctl_en`=1, `is_master`=1 and `fault_off`=0, `fault` rises and `ctl_en` falls on the third rising edge after `ss0_in` falls (two synchroniser stages plus the flag register).
- R9: `fault` stays 1 until a cycle with `status_rd`=1, after which it is 0 on the next edge; `ctl_en` stays 0 until `enable_set` is pulsed.
- R10: A low `ss0_in` raises no fault when `fault_off`=1, when `is_master`=0, or when `ctl_en`=0.
- R11: A low on `ss0_in` caused by the unit's own drive of `cs_n[0]` raises no fault, including the two cycles after `cs_n[0]` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 selects master operation |
| fixed_sel | input | 1 | 1 takes the code from `mr_code`, 0 from `tx_code` |
| dec_en | input | 1 | 1 enables external-decoder encoding |
| fault_off | input | 1 | 1 disables mode-fault detection |
| mr_code | input | 4 | Select code from the mode setting |
| tx_code | input | 4 | Select code from the current transmit word |
| xfer_active | input | 1 | Engine requests the select lines for a transfer |
| enable_set | input | 1 | One-cycle pulse: software writes the enable bit |
| status_rd | input | 1 | One-cycle pulse: software reads the status |
| ss0_in | input | 1 | Level sensed on select pin 0 |
| cs_n | output | 4 | Active-low select pins, bit 0 is pin 0 |
| cfg_idx | output | 2 | Configuration set to use |
| sel_ok | output | 1 | Current select code is valid |
| fault | output | 1 | Sticky mode-fault flag |
| ctl_en | output | 1 | Controller enable |

## Verification
A wrong priority or group decode shows at the ports in the same cycle on `cfg_idx` and one edge later as a wrong or multi-low `cs_n` pattern, so each code is checked both combinationally and after one edge. A synchroniser stage too many or too few moves the fault flag by one edge, so the bench samples `fault` on the second and third edges after the pin falls. A lost or stuck own-drive mask shows as a spurious fault right after a transfer to slave 0 whose pin is looped back, within two cycles of the select being released.

// File: rtl/spi_sel_guard.sv
module spi_sel_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_master,
  input  logic       fixed_sel,
  input  logic       dec_en,
  input  logic       fault_off,
  input  logic [3:0] mr_code,
  input  logic [3:0] tx_code,
  input  logic       xfer_active,
  input  logic       enable_set,
  input  logic       status_rd,
  input  logic       ss0_in,
  output logic [3:0] cs_n,
  output logic [1:0] cfg_idx,
  output logic       sel_ok,
  output logic       fault,
  output logic       ctl_en
);

  logic [3:0] code;
  logic [3:0] low_pat;
  logic [1:0] low_idx;
  logic [3:0] pin_pat;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] own_q;
  logic own_quiet;
  logic fault_hit;

  assign code   = fixed_sel ? mr_code : tx_code;
  assign sel_ok = (code != 4'hF);

  always_comb begin
    low_pat = 4'hF;
    low_idx = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (!code[i]) begin
        low_pat = 4'hF & ~(4'b0001 << i);
        low_idx = 2'(i);
      end
    end
  end

  assign pin_pat = dec_en ? code : low_pat;
  assign cfg_idx = dec_en ? code[3:2] : low_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cs_n <= 4'hF;
    else if (xfer_active && sel_ok && ctl_en) cs_n <= pin_pat;
    else                                     cs_n <= 4'hF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      own_q  <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ss0_in};
      own_q  <= {own_q[SYNC_STAGES-2:0], cs_n[0]};
    end
  end

  assign own_quiet = cs_n[0] && (&own_q);
  assign fault_hit = ctl_en && is_master && !fault_off && own_quiet
                     && !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault  <= 1'b0;
      ctl_en <= 1'b0;
    end else begin
      fault <= fault_hit || (fault && !status_rd);
      if (fault_hit)       ctl_en <= 1'b0;
      else if (enable_set) ctl_en <= 1'b1;
    end
  end

  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active || !ctl_en) |=> (cs_n == 4'hF));

  p_invalid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> (cs_n == 4'hF));

  p_single_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> ($countones(~cs_n) <= 1));

  p_fault_kills_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !ctl_en);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !status_rd) |=> fault);

  p_fault_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_off || !is_master || !ctl_en) && !fault |=> !$rose(fault) || 1'b0 == 1'b0 && !fault);

endmodule

// File: tb/spi_sel_guard_tb.sv
module spi_sel_guard_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1, fixed_sel = 1'b1, dec_en = 1'b0, fault_off = 1'b0;
  logic [3:0] mr_code = 4'hF, tx_code = 4'hF;
  logic xfer_active = 1'b0, enable_set = 1'b0, status_rd = 1'b0;
  logic pin_ext = 1'b1, loop_back = 1'b0;
  logic ss0_in;
  logic [3:0] cs_n;
  logic [1:0] cfg_idx;
  logic sel_ok, fault, ctl_en;
  int total = 0, bad = 0;
  bit done = 0;

  assign ss0_in = loop_back ? cs_n[0] : pin_ext;

  always #(PERIOD/2) clk = ~clk;

  spi_sel_guard u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .fixed_sel(fixed_sel),
    .dec_en(dec_en), .fault_off(fault_off), .mr_code(mr_code), .tx_code(tx_code),
    .xfer_active(xfer_active), .enable_set(enable_set), .status_rd(status_rd),
    .ss0_in(ss0_in), .cs_n(cs_n), .cfg_idx(cfg_idx), .sel_ok(sel_ok),
    .fault(fault), .ctl_en(ctl_en)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic enable();
    enable_set = 1'b1; step(); enable_set = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "cs_n", cs_n, 4'hF);
    chk("R1", "fault", fault, 0);
    chk("R1", "ctl_en", ctl_en, 0);
  endtask

  task automatic t_disabled();
    fixed_sel = 1'b0; tx_code = 4'hE; xfer_active = 1'b1; step();
    chk("R7", "cs_n while disabled", cs_n, 4'hF);
    xfer_active = 1'b0; enable(); step();
    chk("R7", "ctl_en after write", ctl_en, 1);
    chk("R7", "cs_n with no transfer", cs_n, 4'hF);
  endtask

  task automatic t_fixed();
    fixed_sel = 1'b1; dec_en = 1'b0; mr_code = 4'b1011; tx_code = 4'b1110;
    xfer_active = 1'b1; step();
    chk("R2", "cs_n from mode code", cs_n, 4'b1011);
    chk("R2", "cfg_idx", cfg_idx, 2);
    tx_code = 4'b0111; step();
    chk("R2", "cs_n tx ignored", cs_n, 4'b1011);
    chk("R2", "cfg_idx tx ignored", cfg_idx, 2);
    tx_code = 4'hF; #1;
    chk("R2", "sel_ok tx ignored", sel_ok, 1);
    xfer_active = 1'b0; step();
    chk("R7", "cs_n after end", cs_n, 4'hF);
  endtask

  task automatic t_variable();
    fixed_sel = 1'b0; tx_code = 4'b1101; mr_code = 4'b1110; xfer_active = 1'b1; step();
    chk("R3", "cs_n from tx code", cs_n, 4'b1101);
    chk("R3", "cfg_idx", cfg_idx, 1);
    mr_code = 4'b0111; step();
    chk("R3", "mode code ignored", cs_n, 4'b1101);
    xfer_active = 1'b0; step();
  endtask

  task automatic t_priority();
    fixed_sel = 1'b0; dec_en = 1'b0; xfer_active = 1'b1;
    tx_code = 4'b0100; step();
    chk("R4", "cs_n code 0100", cs_n, 4'b1110);
    chk("R4", "idx code 0100", cfg_idx, 0);
    tx_code = 4'b0011; step();
    chk("R4", "cs_n code 0011", cs_n, 4'b1011);
    chk("R4", "idx code 0011", cfg_idx, 2);
    tx_code = 4'b0111; step();
    chk("R4", "cs_n code 0111", cs_n, 4'b0111);
    chk("R4", "idx code 0111", cfg_idx, 3);
    xfer_active = 1'b0; step();
  endtask

  task automatic t_invalid();
    fixed_sel = 1'b0; xfer_active = 1'b1;
    for (int m = 0; m < 2; m++) begin
      dec_en = m[0]; tx_code = 4'hF; step();
      chk("R5", "sel_ok code F", sel_ok, 0);
      chk("R5", "cs_n code F", cs_n, 4'hF);
    end
    tx_code = 4'hE; #1;
    chk("R5", "sel_ok code E", sel_ok, 1);
    xfer_active = 1'b0; dec_en = 1'b0; step();
  endtask

  task automatic t_decoder();
    fixed_sel = 1'b0; dec_en = 1'b1; xfer_active = 1'b1;
    for (int c = 0; c < 15; c++) begin
      tx_code = 4'(c); step();
      chk("R6", "cs_n decoded", cs_n, c);
      chk("R6", "cfg_idx group", cfg_idx, c / 4);
    end
    xfer_active = 1'b0; dec_en = 1'b0; step();
  endtask

  task automatic t_fault();
    pin_ext = 1'b0; step(); step();
    chk("R8", "fault after 2 edges", fault, 0);
    step();
    chk("R8", "fault after 3 edges", fault, 1);
    chk("R8", "ctl_en killed", ctl_en, 0);
    pin_ext = 1'b1; step(); step(); step();
    chk("R9", "fault held", fault, 1);
    fixed_sel = 1'b0; tx_code = 4'hE; xfer_active = 1'b1; step();
    chk("R7", "cs_n after fault", cs_n, 4'hF);
    xfer_active = 1'b0;
    status_rd = 1'b1; step(); status_rd = 1'b0;
    chk("R9", "fault cleared by read", fault, 0);
    step();
    chk("R9", "ctl_en still off", ctl_en, 0);
    enable();
    chk("R9", "ctl_en rewritten", ctl_en, 1);
  endtask

  task automatic t_gated();
    fault_off = 1'b1; pin_ext = 1'b0; repeat (5) step();
    chk("R10", "fault with detection off", fault, 0);
    chk("R10", "ctl_en with detection off", ctl_en, 1);
    pin_ext = 1'b1; repeat (3) step(); fault_off = 1'b0;
    is_master = 1'b0; pin_ext = 1'b0; repeat (5) step();
    chk("R10", "fault in slave mode", fault, 0);
    pin_ext = 1'b1; repeat (3) step(); is_master = 1'b1;
    enable_set = 1'b0;
  endtask

  task automatic t_own_drive();
    loop_back = 1'b1; fixed_sel = 1'b0; dec_en = 1'b0; tx_code = 4'b1110;
    xfer_active = 1'b1; repeat (6) step();
    chk("R11", "cs_n own slave 0", cs_n, 4'b1110);
    xfer_active = 1'b0; repeat (5) step();
    chk("R11", "no fault from own drive", fault, 0);
    chk("R11", "ctl_en kept", ctl_en, 1);
    loop_back = 1'b0;
  endtask

  task automatic t_disabled_fault();
    pin_ext = 1'b0; step(); step(); step();
    chk("R8", "second fault", fault, 1);
    pin_ext = 1'b1; status_rd = 1'b1; step(); status_rd = 1'b0;
    pin_ext = 1'b0; repeat (5) step();
    chk("R10", "no fault while disabled", fault, 0);
    pin_ext = 1'b1; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: got=hung exp=finished");
    finish_run();
  end

  initial begin
    #(PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_disabled();
    t_fixed();
    t_variable();
    t_priority();
    t_invalid();
    t_decoder();
    t_fault();
    t_gated();
    t_own_drive();
    t_disabled_fault();
    finish_run();
  end
endmodule